// File: doc/BRIEF.md
# Timer Output Routing with Pattern Override

This block sits between the fault-handling stage of a timer/counter and its port pins. It takes `N_CH` compare-channel waveform bits and drives `N_OUT` pin outputs. A two-bit routing select first picks one of four ways to spread the channels over the outputs. A pattern stage then lets any output be forced to a constant level in place of its routed channel.

The pattern stage keeps a per-output force-enable word and a per-output level word. Each word has an active copy, which drives the outputs, and a staged copy. A staged write becomes active only on the timer's UPDATE strobe, so every output changes on the same edge. Software that does not need this alignment can write the active copies directly. The final output is registered once.

Top module: `tmr_out_route`

## Requirements
- R1: While `rst_n` is low, and after its release until new inputs arrive, `pin_out` is all zero. The active force-enable and level words reset to zero, and neither staged word is pending.
- R2: With `route_sel` = 0, output k carries channel k mod `N_CH`. Outputs beyond the channel count start again from channel 0.
- R3: With `route_sel` = 1, output k carries channel k mod max(1, `N_CH`/2). Each lower-half channel therefore appears on twice as many outputs.
- R4: With `route_sel` = 2, every output carries channel 0.
- R5: With `route_sel` = 3, output 0 carries channel 0 and every other output carries channel 1.
- R6: When bit k of the active force-enable word is 1, output k equals bit k of the active level word. Otherwise output k equals its routed channel.
- R7: A write to a staged word (`stg_en_we` or `stg_lvl_we`) has no effect on the outputs until the next `update`. At that `update` the staged word becomes active, and all outputs reflect it together.
- R8: Each staged word is pending from its write until the next `update`, which clears it. An `update` with no pending staged word leaves the corresponding active word unchanged.
- R9: A direct write (`act_en_we` or `act_lvl_we`) loads the active word at that clock edge, bypassing the staged copy.
- R10: If a direct write and an `update` fall in the same cycle, the direct write wins. The pending staged word of that kind is discarded, and a later `update` does not apply it.
- R11: `pin_out` reflects `cmp_in`, `route_sel` and the active words exactly one clock after they are presented.
- R12: A staged write in the same cycle as an `update` is not applied by that `update`. That `update` moves the previous pending word, if any, into the active copy. The newly written word stays pending for the next `update`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_in | input | N_CH | Compare-channel waveform bits |
| route_sel | input | 2 | Routing mode select |
| update | input | 1 | Timer UPDATE strobe |
| stg_en_we | input | 1 | Staged force-enable write strobe |
| stg_en_wdata | input | N_OUT | Staged force-enable data |
| stg_lvl_we | input | 1 | Staged level write strobe |
| stg_lvl_wdata | input | N_OUT | Staged level data |
| act_en_we | input | 1 | Direct active force-enable write strobe |
| act_en_wdata | input | N_OUT | Direct active force-enable data |
| act_lvl_we | input | 1 | Direct active level write strobe |
| act_lvl_wdata | input | N_OUT | Direct active level data |
| pin_out | output | N_OUT | Registered pin outputs |

## Verification
The bench uses six outputs over four channels, so routing modes 0 and 1 both have to wrap. A design that indexed the channels without the modulo would put wrong or unknown bits on outputs 4 and 5. The bench runs a second `update` after each transfer; a design that kept the pending flag set would replay stale pattern data after a later direct write. The bench also collides a direct write with an `update`, and a staged write with an `update`. A wrong priority shows up either as the staged word overwriting the direct one, or as a new staged word taking effect one `update` too early.

// File: rtl/tmr_out_route.sv
module tmr_out_route #(
  parameter int N_CH  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  cmp_in,
  input  logic [1:0]       route_sel,
  input  logic             update,
  input  logic             stg_en_we,
  input  logic [N_OUT-1:0] stg_en_wdata,
  input  logic             stg_lvl_we,
  input  logic [N_OUT-1:0] stg_lvl_wdata,
  input  logic             act_en_we,
  input  logic [N_OUT-1:0] act_en_wdata,
  input  logic             act_lvl_we,
  input  logic [N_OUT-1:0] act_lvl_wdata,
  output logic [N_OUT-1:0] pin_out
);
  localparam int HALF   = (N_CH / 2 > 0) ? N_CH / 2 : 1;
  localparam int SECOND = (N_CH > 1) ? 1 : 0;

  logic [N_OUT-1:0] routed, mixed;
  logic [N_OUT-1:0] en_act, lvl_act, en_stg, lvl_stg;
  logic             en_pend, lvl_pend;
  logic             past_ok;

  for (genvar k = 0; k < N_OUT; k++) begin : g_route
    always_comb begin
      unique case (route_sel)
        2'd0:    routed[k] = cmp_in[k % N_CH];
        2'd1:    routed[k] = cmp_in[k % HALF];
        2'd2:    routed[k] = cmp_in[0];
        default: routed[k] = (k == 0) ? cmp_in[0] : cmp_in[SECOND];
      endcase
    end
  end

  assign mixed = (routed & ~en_act) | (lvl_act & en_act);

  always_ff @(posedge clk) begin
    if (!rst_n) pin_out <= '0;
    else        pin_out <= mixed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_act  <= '0;
      en_stg  <= '0;
      en_pend <= 1'b0;
    end else begin
      if (act_en_we)              en_act <= act_en_wdata;
      else if (update && en_pend) en_act <= en_stg;
      if (stg_en_we) begin
        en_stg  <= stg_en_wdata;
        en_pend <= 1'b1;
      end else if (update) begin
        en_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_act  <= '0;
      lvl_stg  <= '0;
      lvl_pend <= 1'b0;
    end else begin
      if (act_lvl_we)              lvl_act <= act_lvl_wdata;
      else if (update && lvl_pend) lvl_act <= lvl_stg;
      if (stg_lvl_we) begin
        lvl_stg  <= stg_lvl_wdata;
        lvl_pend <= 1'b1;
      end else if (update) begin
        lvl_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (pin_out == '0));

  // R4
  fanout_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(route_sel) == 2'd2 && $past(en_act) == '0)
      |-> (pin_out == {N_OUT{$past(cmp_in[0])}}));

  // R6
  forced_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pin_out & $past(en_act)) == ($past(lvl_act) & $past(en_act))));

  // R9
  direct_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(act_en_we)) |-> (en_act == $past(act_en_wdata)));

  // R8
  idle_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(update && !en_pend && !act_en_we)) |-> $stable(en_act));

  // R10
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(update && !stg_lvl_we)) |-> !lvl_pend);
endmodule

// File: tb/tmr_out_route_test.sv
module tmr_out_route_test;
  localparam int NC = 4;
  localparam int NO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] cmp_in = '0;
  logic [1:0] route_sel = 2'd0;
  logic update = 1'b0;
  logic stg_en_we = 1'b0, stg_lvl_we = 1'b0, act_en_we = 1'b0, act_lvl_we = 1'b0;
  logic [NO-1:0] stg_en_wdata = '0, stg_lvl_wdata = '0, act_en_wdata = '0, act_lvl_wdata = '0;
  logic [NO-1:0] pin_out;

  always #5 clk = ~clk;

  tmr_out_route #(.N_CH(NC), .N_OUT(NO)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .route_sel(route_sel), .update(update),
    .stg_en_we(stg_en_we), .stg_en_wdata(stg_en_wdata),
    .stg_lvl_we(stg_lvl_we), .stg_lvl_wdata(stg_lvl_wdata),
    .act_en_we(act_en_we), .act_en_wdata(act_en_wdata),
    .act_lvl_we(act_lvl_we), .act_lvl_wdata(act_lvl_wdata),
    .pin_out(pin_out));

  int checks = 0, fails = 0;
  string tag = "R1";

  bit [NO-1:0] m_en, m_lvl, m_ens, m_lvls, m_pin;
  bit m_ep, m_lp;

  function automatic int src_of(int k, int sel);
    int half = (NC / 2 > 0) ? NC / 2 : 1;
    case (sel)
      0: return k % NC;
      1: return k % half;
      2: return 0;
      default: return (k == 0) ? 0 : 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_lvl = '0; m_ens = '0; m_lvls = '0; m_pin = '0; m_ep = 0; m_lp = 0;
    end else begin
      for (int k = 0; k < NO; k++)
        m_pin[k] = m_en[k] ? m_lvl[k] : cmp_in[src_of(k, route_sel)];
      if (act_en_we) m_en = act_en_wdata;
      else if (update && m_ep) m_en = m_ens;
      if (act_lvl_we) m_lvl = act_lvl_wdata;
      else if (update && m_lp) m_lvl = m_lvls;
      if (update) begin m_ep = 0; m_lp = 0; end
      if (stg_en_we) begin m_ens = stg_en_wdata; m_ep = 1; end
      if (stg_lvl_we) begin m_lvls = stg_lvl_wdata; m_lp = 1; end
    end
  end

  task automatic check(string req, logic [NO-1:0] got, logic [NO-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s pin_out=%b expected %b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(tag, pin_out, m_pin);
    update = 0; stg_en_we = 0; stg_lvl_we = 0; act_en_we = 0; act_lvl_we = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      cmp_in = NC'($urandom);
      tick();
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    cmp_in = '1;
    repeat (3) @(negedge clk);
    check("R1", pin_out, '0);
    rst_n = 1;
    cmp_in = '0;
    tag = "R1"; tick();
    check("R1", pin_out, '0);

    route_sel = 0; tag = "R2"; run(12);
    route_sel = 1; tag = "R3"; run(12);
    route_sel = 2; tag = "R4"; run(12);
    route_sel = 3; tag = "R5"; run(12);

    tag = "R11"; route_sel = 0;
    for (int i = 0; i < 8; i++) begin
      cmp_in = (i % 2 == 0) ? 4'b1010 : 4'b0101;
      route_sel = 2'(i % 4);
      tick();
    end

    tag = "R9"; route_sel = 0;
    act_en_we = 1; act_en_wdata = 6'b000101;
    act_lvl_we = 1; act_lvl_wdata = 6'b000100;
    tick();
    tag = "R6"; run(6);
    cmp_in = 4'b1111; tick();
    check("R6", pin_out, 6'b111110);

    tag = "R7";
    stg_en_we = 1; stg_en_wdata = 6'b111111;
    stg_lvl_we = 1; stg_lvl_wdata = 6'b101010;
    tick(); run(3);
    update = 1; tick();
    cmp_in = 4'b0000; tick();
    check("R7", pin_out, 6'b101010);

    tag = "R8";
    act_en_we = 1; act_en_wdata = 6'b000000; tick();
    update = 1; tick();
    cmp_in = 4'b1011; tick();
    check("R8", pin_out, 6'b111011);
    run(3);

    tag = "R10";
    stg_en_we = 1; stg_en_wdata = 6'b111111;
    stg_lvl_we = 1; stg_lvl_wdata = 6'b111111;
    tick();
    update = 1; act_en_we = 1; act_en_wdata = 6'b000011;
    act_lvl_we = 1; act_lvl_wdata = 6'b000001;
    tick();
    update = 1; tick();
    cmp_in = 4'b0000; tick();
    check("R10", pin_out, 6'b000001);
    run(3);

    tag = "R12";
    act_en_we = 1; act_en_wdata = 6'b111111; tick();
    stg_lvl_we = 1; stg_lvl_wdata = 6'b010101; tick();
    update = 1; stg_lvl_we = 1; stg_lvl_wdata = 6'b110011; tick();
    tick();
    check("R12", pin_out, 6'b010101);
    update = 1; tick();
    tick();
    check("R12", pin_out, 6'b110011);
    run(3);

    finish_up();
  end
endmodule